// File: doc/BRIEF.md
# Execute-Stage ALU with Condition Flags and Branch Resolution

This block is the arithmetic core of the execute stage in a small pipelined processor. Each cycle it takes a 4-bit function code, a destination operand, a source operand, an immediate word and an immediate-select bit. It produces a result word at once, with no register in the path. It keeps three condition flags, zero, negative and carry, in a register. The flags change only on clock edges where the pipeline slot is marked valid, so stalled or flushed slots leave them alone.

Branch resolution uses the same stored flags. When branch-enable is high, a 2-bit condition code picks which flag is tested, or marks the branch as unconditional. The taken output tells fetch to redirect. When a conditional branch is taken, the flag it tested is cleared at the next edge, and the branch is counted as having used that flag.

Top module: `exec_alu_unit`

## Requirements
- R1: A synchronous active-high reset clears the flag register to 000. `flags_o` bit 0 is zero (Z), bit 1 is negative (N) and bit 2 is carry (C).
- R2: The flag register changes only at an edge where `valid_i` is high. When `valid_i` is low the flags hold, whatever the function code.
- R3: Function code 0000 (no-op) gives result = destination operand and changes no flag. Codes 1110 and 1111 behave the same way.
- R4: Code 0001 sets C and code 0010 clears C. Both give result = destination operand and leave Z and N unchanged.
- R5: Code 0011 gives result = the effective second operand. Code 0100 gives result = the destination operand. Neither changes a flag.
- R6: When `imm_sel_i` is high, `imm_i` replaces `opb_i` as the second operand for every function code that uses it.
- R7: Code 0101 is bitwise NOT, 0110 is +1 and 0111 is -1, each applied to the destination operand. Increment sets C to the carry-out. Decrement sets C to the borrow, which is 1 only when the operand was 0. NOT leaves C unchanged.
- R8: Code 1000 is destination + second operand, with C = carry-out. Code 1001 is destination - second operand, with C = borrow (1 when the destination is unsigned-less than the second operand).
- R9: Code 1010 is bitwise AND and code 1011 is bitwise OR. Both leave C unchanged.
- R10: Code 1100 shifts left and code 1101 shifts right (logical). The shift amount is the low 4 bits of the second operand. C takes the last bit shifted out. With an amount of 0 the result is the operand and C is unchanged.
- R11: Codes 0101 to 1101 set Z when the result is 0 and set N to the result's top bit.
- R12: `taken_o` is combinational from the stored flags. It is high only when `valid_i` and `br_en_i` are both high and the condition holds. Condition 00 tests Z, 01 tests N, 10 tests C, and 11 is always true.
- R13: A taken branch with condition 00, 01 or 10 clears the tested flag at the next edge. This clear overrides any update from the same cycle's function code. Condition 11 clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| valid_i | input | 1 | Slot holds a live instruction; enables the flag update and branch |
| func_i | input | 4 | Function code |
| opa_i | input | 16 | Destination operand |
| opb_i | input | 16 | Source operand |
| imm_i | input | 16 | Immediate word |
| imm_sel_i | input | 1 | Use the immediate instead of the source operand |
| br_en_i | input | 1 | Instruction is a branch |
| br_type_i | input | 2 | Branch condition code |
| result_o | output | 16 | Result word |
| taken_o | output | 1 | Branch redirects fetch |
| flags_o | output | 3 | Stored flags {C, N, Z} |

## Verification
A chained vector table runs every function code with operands chosen to separate close cases. These include a carry out of FFFF+1 against a signed overflow with no carry, a borrow against an equal subtract, decrement from zero against decrement to zero, and a shift amount whose low 4 bits are zero against one that moves a bit into carry. Each vector starts from the flags the previous one left behind. This shows whether carry survives AND, OR and NOT, and whether set-carry and clear-carry leave Z and N untouched. Immediate vectors pair a register operand and an immediate that would give different results, so a missing select shows up. Directed sequences cover each branch condition both taken and not taken, the gating by branch-enable and by valid, flag clearing after a taken branch including its priority over a same-cycle update, and reset in the middle of a run.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [3:0] {
    FN_NOP    = 4'b0000,
    FN_SETC   = 4'b0001,
    FN_CLRC   = 4'b0010,
    FN_PASS_B = 4'b0011,
    FN_PASS_A = 4'b0100,
    FN_NOT    = 4'b0101,
    FN_INC    = 4'b0110,
    FN_DEC    = 4'b0111,
    FN_ADD    = 4'b1000,
    FN_SUB    = 4'b1001,
    FN_AND    = 4'b1010,
    FN_OR     = 4'b1011,
    FN_SHL    = 4'b1100,
    FN_SHR    = 4'b1101
  } exu_fn_e;

  typedef enum logic [1:0] {
    BR_ZERO   = 2'b00,
    BR_NEG    = 2'b01,
    BR_CARRY  = 2'b10,
    BR_ALWAYS = 2'b11
  } exu_cond_e;

  typedef struct packed {
    logic c;
    logic n;
    logic z;
  } exu_flags_t;

endpackage

// File: rtl/exu_operand_sel.sv
module exu_operand_sel #(
  parameter int W = 16
) (
  input  logic [W-1:0] opb,
  input  logic [W-1:0] imm,
  input  logic         use_imm,
  output logic [W-1:0] second
);
  assign second = use_imm ? imm : opb;
endmodule

// File: rtl/exu_alu_core.sv
module exu_alu_core
  import exu_pkg::*;
#(
  parameter int W   = 16,
  parameter int SHW = 4
) (
  input  logic [3:0]   fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         zn_we,
  output logic         c_we,
  output logic         c_new
);

  function automatic logic [W:0] add_ext(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [W:0] sub_ext(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  function automatic logic [W:0] shl_ext(input logic [W-1:0] x, input logic [SHW-1:0] amt);
    return {1'b0, x} << amt;
  endfunction

  function automatic logic [W:0] shr_ext(input logic [W-1:0] x, input logic [SHW-1:0] amt);
    return {x, 1'b0} >> amt;
  endfunction

  localparam logic [W-1:0] ONE = W'(1);

  logic [SHW-1:0] amt;
  logic [W:0]     wide;

  assign amt = b[SHW-1:0];

  always_comb begin
    res   = a;
    zn_we = 1'b0;
    c_we  = 1'b0;
    c_new = 1'b0;
    wide  = '0;
    unique case (fn)
      FN_SETC:   begin c_we = 1'b1; c_new = 1'b1; end
      FN_CLRC:   begin c_we = 1'b1; c_new = 1'b0; end
      FN_PASS_B: res = b;
      FN_PASS_A: res = a;
      FN_NOT:    begin res = ~a; zn_we = 1'b1; end
      FN_INC: begin
        wide = add_ext(a, ONE);
        res = wide[W-1:0]; zn_we = 1'b1; c_we = 1'b1; c_new = wide[W];
      end
      FN_DEC: begin
        wide = sub_ext(a, ONE);
        res = wide[W-1:0]; zn_we = 1'b1; c_we = 1'b1; c_new = wide[W];
      end
      FN_ADD: begin
        wide = add_ext(a, b);
        res = wide[W-1:0]; zn_we = 1'b1; c_we = 1'b1; c_new = wide[W];
      end
      FN_SUB: begin
        wide = sub_ext(a, b);
        res = wide[W-1:0]; zn_we = 1'b1; c_we = 1'b1; c_new = wide[W];
      end
      FN_AND:    begin res = a & b; zn_we = 1'b1; end
      FN_OR:     begin res = a | b; zn_we = 1'b1; end
      FN_SHL: begin
        wide = shl_ext(a, amt);
        res = wide[W-1:0]; zn_we = 1'b1;
        c_we = (amt != '0); c_new = wide[W];
      end
      FN_SHR: begin
        wide = shr_ext(a, amt);
        res = wide[W:1]; zn_we = 1'b1;
        c_we = (amt != '0); c_new = wide[0];
      end
      default: res = a;
    endcase
  end

endmodule

// File: rtl/exu_branch_eval.sv
module exu_branch_eval
  import exu_pkg::*;
(
  input  exu_flags_t flags,
  input  logic       valid,
  input  logic       br_en,
  input  logic [1:0] br_type,
  output logic       taken,
  output exu_flags_t clr_mask
);
  logic cond;

  always_comb begin
    unique case (br_type)
      BR_ZERO:  cond = flags.z;
      BR_NEG:   cond = flags.n;
      BR_CARRY: cond = flags.c;
      default:  cond = 1'b1;
    endcase
  end

  assign taken = valid & br_en & cond;

  always_comb begin
    clr_mask = '0;
    if (taken) begin
      unique case (br_type)
        BR_ZERO:  clr_mask.z = 1'b1;
        BR_NEG:   clr_mask.n = 1'b1;
        BR_CARRY: clr_mask.c = 1'b1;
        default:  clr_mask   = '0;
      endcase
    end
  end
endmodule

// File: rtl/exec_alu_unit.sv
module exec_alu_unit
  import exu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_i,
  input  logic [3:0]   func_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [W-1:0] imm_i,
  input  logic         imm_sel_i,
  input  logic         br_en_i,
  input  logic [1:0]   br_type_i,
  output logic [W-1:0] result_o,
  output logic         taken_o,
  output logic [2:0]   flags_o
);
  localparam int SHW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] second_op;
  logic         flag_upd_zn;
  logic         flag_upd_c;
  logic         carry_next;
  exu_flags_t   flags_q;
  exu_flags_t   alu_flags;
  exu_flags_t   br_clr_mask;
  exu_flags_t   flags_d;

  exu_operand_sel #(.W(W)) u_opsel (
    .opb     (opb_i),
    .imm     (imm_i),
    .use_imm (imm_sel_i),
    .second  (second_op)
  );

  exu_alu_core #(.W(W), .SHW(SHW)) u_core (
    .fn    (func_i),
    .a     (opa_i),
    .b     (second_op),
    .res   (result_o),
    .zn_we (flag_upd_zn),
    .c_we  (flag_upd_c),
    .c_new (carry_next)
  );

  exu_branch_eval u_br (
    .flags    (flags_q),
    .valid    (valid_i),
    .br_en    (br_en_i),
    .br_type  (br_type_i),
    .taken    (taken_o),
    .clr_mask (br_clr_mask)
  );

  always_comb begin
    alu_flags = flags_q;
    if (flag_upd_zn) begin
      alu_flags.z = (result_o == '0);
      alu_flags.n = result_o[W-1];
    end
    if (flag_upd_c) alu_flags.c = carry_next;
    flags_d = alu_flags & ~br_clr_mask;
  end

  always_ff @(posedge clk) begin
    if (rst)          flags_q <= '0;
    else if (valid_i) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/exec_alu_unit_chk.sv
module exec_alu_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         valid_i,
  input logic [3:0]   func_i,
  input logic         br_en_i,
  input logic [1:0]   br_type_i,
  input logic [W-1:0] result_o,
  input logic         taken_o,
  input logic [2:0]   flags_o
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> flags_o == 3'b000);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(flags_o));

  a_r4_setc: assert property (@(posedge clk) disable iff (rst)
    (valid_i && func_i == 4'b0001 && !taken_o)
      |=> (flags_o[2] && flags_o[1:0] == $past(flags_o[1:0])));

  a_r4_clrc: assert property (@(posedge clk) disable iff (rst)
    (valid_i && func_i == 4'b0010 && !taken_o)
      |=> (!flags_o[2] && flags_o[1:0] == $past(flags_o[1:0])));

  a_r11_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (valid_i && func_i >= 4'b0101 && func_i <= 4'b1101 && !taken_o)
      |=> flags_o[0] == ($past(result_o) == '0));

  a_r12_taken_gated: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (valid_i && br_en_i));

  a_r12_always_taken: assert property (@(posedge clk) disable iff (rst)
    (valid_i && br_en_i && br_type_i == 2'b11) |-> taken_o);

  a_r13_zero_cleared: assert property (@(posedge clk) disable iff (rst)
    (taken_o && br_type_i == 2'b00) |=> !flags_o[0]);

  a_r13_carry_cleared: assert property (@(posedge clk) disable iff (rst)
    (taken_o && br_type_i == 2'b10) |=> !flags_o[2]);

endmodule

bind exec_alu_unit exec_alu_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid_i   (valid_i),
  .func_i    (func_i),
  .br_en_i   (br_en_i),
  .br_type_i (br_type_i),
  .result_o  (result_o),
  .taken_o   (taken_o),
  .flags_o   (flags_o)
);

// File: tb/exec_alu_unit_bench.sv
module exec_alu_unit_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [3:0]  func_i;
  logic [15:0] opa_i, opb_i, imm_i;
  logic        imm_sel_i;
  logic        br_en_i;
  logic [1:0]  br_type_i;
  logic [15:0] result_o;
  logic        taken_o;
  logic [2:0]  flags_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  exec_alu_unit u_exec_alu_unit (
    .clk(clk), .rst(rst), .valid_i(valid_i), .func_i(func_i),
    .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i), .imm_sel_i(imm_sel_i),
    .br_en_i(br_en_i), .br_type_i(br_type_i),
    .result_o(result_o), .taken_o(taken_o), .flags_o(flags_o)
  );

  // func, a, b, imm, sel, expected result, expected flags {C,N,Z} after the edge
  typedef struct packed {
    logic [3:0]  f;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] imm;
    logic        sel;
    logic [15:0] res;
    logic [2:0]  fl;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{4'h1, 16'h1234, 16'h0000, 16'h0000, 1'b0, 16'h1234, 3'b100}, // R4 set C
    '{4'h0, 16'h00FF, 16'h0000, 16'h0000, 1'b0, 16'h00FF, 3'b100}, // R3
    '{4'h2, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0000, 3'b000}, // R4 clr C, Z untouched
    '{4'h8, 16'hFFFF, 16'h0001, 16'h0000, 1'b0, 16'h0000, 3'b101}, // R8 carry out
    '{4'h8, 16'h7000, 16'h1000, 16'h0000, 1'b0, 16'h8000, 3'b010}, // R8 R11 negative
    '{4'h9, 16'h0003, 16'h0005, 16'h0000, 1'b0, 16'hFFFE, 3'b110}, // R8 borrow
    '{4'h9, 16'h0005, 16'h0005, 16'h0000, 1'b0, 16'h0000, 3'b001}, // R8 equal
    '{4'h1, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0000, 3'b101}, // R4
    '{4'hA, 16'hF0F0, 16'h0F0F, 16'h0000, 1'b0, 16'h0000, 3'b101}, // R9 C kept
    '{4'hB, 16'h8000, 16'h0001, 16'h0000, 1'b0, 16'h8001, 3'b110}, // R9
    '{4'h5, 16'h00FF, 16'h0000, 16'h0000, 1'b0, 16'hFF00, 3'b110}, // R7 NOT
    '{4'h6, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 16'h0000, 3'b101}, // R7 inc wrap
    '{4'h6, 16'h0010, 16'h0000, 16'h0000, 1'b0, 16'h0011, 3'b000}, // R7
    '{4'h7, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'hFFFF, 3'b110}, // R7 dec borrow
    '{4'h7, 16'h0001, 16'h0000, 16'h0000, 1'b0, 16'h0000, 3'b001}, // R7
    '{4'hC, 16'h8001, 16'h0001, 16'h0000, 1'b0, 16'h0002, 3'b100}, // R10 shl carry
    '{4'hC, 16'h0001, 16'h0010, 16'h0000, 1'b0, 16'h0001, 3'b100}, // R10 amount 0
    '{4'hD, 16'h0004, 16'h0002, 16'h0000, 1'b0, 16'h0001, 3'b000}, // R10 shr
    '{4'hD, 16'hC000, 16'h1234, 16'h000F, 1'b1, 16'h0001, 3'b100}, // R10 R6
    '{4'h3, 16'h0000, 16'hABCD, 16'h0000, 1'b0, 16'hABCD, 3'b100}, // R5
    '{4'h3, 16'h0000, 16'hABCD, 16'h0042, 1'b1, 16'h0042, 3'b100}, // R5 R6
    '{4'h4, 16'h5555, 16'hAAAA, 16'h0000, 1'b0, 16'h5555, 3'b100}, // R5
    '{4'h8, 16'h0001, 16'hFFFF, 16'h0002, 1'b1, 16'h0003, 3'b000}, // R6
    '{4'h9, 16'h0010, 16'h0000, 16'h0001, 1'b1, 16'h000F, 3'b000}, // R6
    '{4'hC, 16'h0001, 16'h0000, 16'h0004, 1'b1, 16'h0010, 3'b000}  // R6 R10
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] f, input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] im, input logic sel, input logic ben,
                       input logic [1:0] bt, input logic v);
    @(negedge clk);
    func_i = f; opa_i = a; opb_i = b; imm_i = im; imm_sel_i = sel;
    br_en_i = ben; br_type_i = bt; valid_i = v;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; valid_i = 1'b0; func_i = 4'h0; opa_i = '0; opb_i = '0; imm_i = '0;
    imm_sel_i = 1'b0; br_en_i = 1'b0; br_type_i = 2'b00;
    tick(); tick();
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 reset flags", 32'(flags_o), 32'b000);
    check("R12 taken after reset", 32'(taken_o), 32'b0);

    // vector table, each entry starting from the previous entry's flags
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].f, TBL[i].a, TBL[i].b, TBL[i].imm, TBL[i].sel, 1'b0, 2'b00, 1'b1);
      check($sformatf("R3-R11 vec %0d result", i), 32'(result_o), 32'(TBL[i].res));
      tick();
      check($sformatf("R3-R11 vec %0d flags", i), 32'(flags_o), 32'(TBL[i].fl));
    end

    // R2: no flag update with valid low
    drive(4'h1, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 2'b00, 1'b1); tick();
    drive(4'h8, 16'hFFFF, 16'h0001, 16'h0, 1'b0, 1'b0, 2'b00, 1'b0);
    tick();
    check("R2 flags hold when invalid", 32'(flags_o), 32'b100);

    // R12 R13: carry branch taken and flag cleared
    drive(4'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, 2'b10, 1'b1);
    check("R12 carry branch taken", 32'(taken_o), 32'b1);
    tick();
    check("R13 carry cleared", 32'(flags_o), 32'b000);
    drive(4'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, 2'b10, 1'b1);
    check("R12 carry branch not taken", 32'(taken_o), 32'b0);
    tick();

    // R12: gating by branch enable and valid
    drive(4'h1, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 2'b11, 1'b1);
    check("R12 no branch enable", 32'(taken_o), 32'b0);
    tick();
    drive(4'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, 2'b11, 1'b0);
    check("R12 invalid slot", 32'(taken_o), 32'b0);
    drive(4'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, 2'b11, 1'b1);
    check("R12 unconditional taken", 32'(taken_o), 32'b1);
    tick();
    check("R13 unconditional clears nothing", 32'(flags_o), 32'b100);

    // R12 R13: zero branch, clear overrides same-cycle update
    drive(4'h9, 16'h0005, 16'h0005, 16'h0, 1'b0, 1'b0, 2'b00, 1'b1); tick();
    check("R8 equal subtract flags", 32'(flags_o), 32'b001);
    drive(4'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, 2'b01, 1'b1);
    check("R12 negative branch not taken", 32'(taken_o), 32'b0);
    tick();
    drive(4'h9, 16'h0005, 16'h0005, 16'h0, 1'b0, 1'b1, 2'b00, 1'b1);
    check("R12 zero branch taken", 32'(taken_o), 32'b1);
    tick();
    check("R13 zero clear wins over update", 32'(flags_o), 32'b000);

    // R12 R13: negative branch
    drive(4'h8, 16'h7000, 16'h1000, 16'h0, 1'b0, 1'b0, 2'b00, 1'b1); tick();
    drive(4'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, 2'b01, 1'b1);
    check("R12 negative branch taken", 32'(taken_o), 32'b1);
    tick();
    check("R13 negative cleared", 32'(flags_o), 32'b000);

    // R1: reset during a run beats a valid update
    drive(4'h1, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 2'b00, 1'b1); tick();
    check("R4 carry set before reset", 32'(flags_o), 32'b100);
    drive(4'h1, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 2'b00, 1'b1);
    rst = 1'b1;
    tick();
    check("R1 mid-run reset", 32'(flags_o), 32'b000);
    @(negedge clk); rst = 1'b0; valid_i = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule